// File: doc/BRIEF.md
# Instruction Cache Fetch Controller

This block is a read-only, set-associative instruction cache that sits between an instruction fetch frontend and memory. The frontend hands it a virtual fetch address. Lines are indexed with virtual address bits and tagged with physical ones. While a lookup is in progress, the block asks a translation port for the physical line address. In the cycle the translation answers, the block compares the physical tag against every way of the selected set. On a hit it returns the whole line at once. On a miss it issues a line-aligned read on a request/grant/response memory port, returns the line, and installs it.

Fetches issued while caching is disabled go straight to memory at the virtual address and are never installed. Tag, data and valid storage are register arrays inside the block. The default configuration is 16 kB, 4 ways and 128-bit lines, which gives 256 sets.

A kill may arrive at any point. If a translation or a memory read is outstanding, the controller keeps that exchange going until it completes, then drops its result. A flush clears all valid bits, one set per cycle, and writes nothing back.

Top module: `icache_fetch_ctrl`

## Requirements
- R1: Each memory read address is line aligned: its low 4 bits are zero and its upper bits are the physical line address of the fetch.
- R2: After reset, and after any flush, `fetch_ready_o` stays low for one cycle per set (256 cycles), and every valid bit is cleared. A line cached before a flush misses afterwards.
- R3: In the cycle after a fetch is accepted with caching enabled, `xlat_req_o` rises with `xlat_vaddr_o` equal to the fetch address. A hit returns `fetch_valid_o` with the line in the cycle `xlat_valid_i` is high. `xlat_req_o` and `mem_req_o` are never high together.
- R4: In a hit cycle `fetch_ready_o` is high, unless a flush is pending, so the next fetch is accepted in that same cycle with no idle cycle in between.
- R5: A miss raises `mem_req_o` and holds it, with the address stable, until `mem_gnt_i`. The line is returned to the frontend in the cycle `mem_rvalid_i` is high and is installed. A later fetch of the same line hits without any memory read.
- R6: On install, the victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the way given by the LFSR's low two bits. The LFSR is 8 bits, is seeded to 0xA5 at reset, and on each install shifts left with bit 7 xor bit 5 xor bit 4 xor bit 3 entering at bit 0.
- R7: A fetch accepted while `cache_en_i` is low issues no translation request. It reads memory at its own line-aligned virtual address, returns the data, and installs nothing.
- R8: A kill during translation suppresses the result. `xlat_req_o` and its address are held until `xlat_valid_i`, and the controller then returns to idle.
- R9: A kill during a refill lets the memory request and its response complete, does not return the data to the frontend, and does not install the line.
- R10: While `kill_i` is high, `fetch_ready_o` and `fetch_valid_o` are low.
- R11: A flush that arrives while a fetch is in progress waits for that fetch to finish. The fetch's data is still returned, and the sweep of R2 then runs, with `fetch_ready_o` low from the cycle after the flush until the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_en_i | input | 1 | Caching enabled for fetches accepted now |
| flush_i | input | 1 | Invalidate the whole cache |
| kill_i | input | 1 | Abandon the fetch in progress |
| fetch_req_i | input | 1 | Fetch request valid |
| fetch_vaddr_i | input | 32 | Virtual fetch address |
| fetch_ready_o | output | 1 | Fetch request accepted this cycle |
| fetch_valid_o | output | 1 | Fetch data valid |
| fetch_data_o | output | 128 | Returned cache line |
| xlat_req_o | output | 1 | Translation request |
| xlat_vaddr_o | output | 32 | Address to translate |
| xlat_valid_i | input | 1 | Translation answer valid |
| xlat_pline_i | input | 28 | Physical line address (physical address bits 31:4) |
| mem_req_o | output | 1 | Memory line read request |
| mem_addr_o | output | 32 | Line-aligned physical read address |
| mem_gnt_i | input | 1 | Memory request granted |
| mem_rvalid_i | input | 1 | Memory line data valid |
| mem_rdata_i | input | 128 | Memory line data |

## Verification
Several cases put two events in the same cycle. A kill can land in the cycle a translation answers with a hit, which tests that the hit is dropped. A kill can also land while a refill is still outstanding. A chained request can land in a hit cycle, and a flush can arrive while a refill is in flight. Each case is provoked by stepping the bench until its reference model reaches the targeted phase, then asserting the event for exactly one cycle. The cycle-accurate model is then compared with every output on every clock. Per-scenario counts of returned lines, memory reads, acceptance gaps and ready-low cycles are compared with hand-derived values.

// File: rtl/icache_fetch_ctrl.sv
module icache_fetch_ctrl #(
  parameter int VADDR_W     = 32,
  parameter int PADDR_W     = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int WAYS        = 4,
  parameter int LINE_BITS   = 128,
  parameter int LFSR_W      = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  localparam int PLINE_W    = PADDR_W - $clog2(LINE_BITS/8)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cache_en_i,
  input  logic                 flush_i,
  input  logic                 kill_i,
  input  logic                 fetch_req_i,
  input  logic [VADDR_W-1:0]   fetch_vaddr_i,
  output logic                 fetch_ready_o,
  output logic                 fetch_valid_o,
  output logic [LINE_BITS-1:0] fetch_data_o,
  output logic                 xlat_req_o,
  output logic [VADDR_W-1:0]   xlat_vaddr_o,
  input  logic                 xlat_valid_i,
  input  logic [PLINE_W-1:0]   xlat_pline_i,
  output logic                 mem_req_o,
  output logic [PADDR_W-1:0]   mem_addr_o,
  input  logic                 mem_gnt_i,
  input  logic                 mem_rvalid_i,
  input  logic [LINE_BITS-1:0] mem_rdata_i
);
  localparam int LINE_BYTES = LINE_BITS / 8;
  localparam int OFS_W      = $clog2(LINE_BYTES);
  localparam int SETS       = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = PADDR_W - OFS_W - IDX_W;
  localparam int WAY_W      = $clog2(WAYS);

  typedef enum logic [2:0] {
    S_FLUSH, S_IDLE, S_LOOK, S_XKILL, S_REQ, S_RKILL, S_WAIT, S_WKILL
  } st_t;

  st_t                 st_q, st_d;
  logic [VADDR_W-1:0]  vaddr_q;
  logic                byp_q;
  logic [PLINE_W-1:0]  pline_q;
  logic                pend_q, pend_d;
  logic [IDX_W-1:0]    fidx_q;
  logic [LFSR_W-1:0]   lfsr_q;
  logic                accept, install;

  logic [WAYS-1:0]      vld_q  [SETS];
  logic [TAG_W-1:0]     tag_q  [WAYS][SETS];
  logic [LINE_BITS-1:0] data_q [WAYS][SETS];

  logic [IDX_W-1:0]     idx;
  logic [TAG_W-1:0]     ptag;
  logic [WAYS-1:0]      way_hit;
  logic                 hit;
  logic [LINE_BITS-1:0] hit_data;
  logic [WAY_W-1:0]     victim;

  assign idx  = vaddr_q[OFS_W +: IDX_W];
  assign ptag = xlat_pline_i[PLINE_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = vld_q[idx][w] && (tag_q[w][idx] == ptag);
  end
  assign hit = |way_hit;

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_data |= data_q[w][idx];
  end

  always_comb begin
    victim = lfsr_q[WAY_W-1:0];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[idx][w]) victim = WAY_W'(w);
  end

  always_comb begin
    st_d          = st_q;
    pend_d        = pend_q | flush_i;
    fetch_ready_o = 1'b0;
    fetch_valid_o = 1'b0;
    xlat_req_o    = 1'b0;
    mem_req_o     = 1'b0;
    install       = 1'b0;
    case (st_q)
      S_FLUSH: if (fidx_q == IDX_W'(SETS - 1)) st_d = S_IDLE;
      S_IDLE: begin
        if (pend_d) begin
          st_d   = S_FLUSH;
          pend_d = 1'b0;
        end else begin
          fetch_ready_o = !kill_i;
          if (fetch_req_i && !kill_i) st_d = S_LOOK;
        end
      end
      S_LOOK: begin
        xlat_req_o = !byp_q;
        if (byp_q) st_d = kill_i ? S_IDLE : S_REQ;
        else if (xlat_valid_i) begin
          if (kill_i) st_d = S_IDLE;
          else if (hit) begin
            fetch_valid_o = 1'b1;
            fetch_ready_o = !pend_d;
            st_d = (fetch_req_i && !pend_d) ? S_LOOK : S_IDLE;
          end else st_d = S_REQ;
        end else if (kill_i) st_d = S_XKILL;
      end
      S_XKILL: begin
        xlat_req_o = 1'b1;
        if (xlat_valid_i) st_d = S_IDLE;
      end
      S_REQ: begin
        mem_req_o = 1'b1;
        if (mem_gnt_i) st_d = kill_i ? S_WKILL : S_WAIT;
        else if (kill_i) st_d = S_RKILL;
      end
      S_RKILL: begin
        mem_req_o = 1'b1;
        if (mem_gnt_i) st_d = S_WKILL;
      end
      S_WAIT: begin
        if (mem_rvalid_i) begin
          fetch_valid_o = !kill_i;
          install       = !kill_i && !byp_q;
          st_d          = S_IDLE;
        end else if (kill_i) st_d = S_WKILL;
      end
      S_WKILL: if (mem_rvalid_i) st_d = S_IDLE;
    endcase
  end

  assign accept       = fetch_ready_o && fetch_req_i;
  assign xlat_vaddr_o = vaddr_q;
  assign mem_addr_o   = {pline_q, {OFS_W{1'b0}}};
  assign fetch_data_o = (st_q == S_WAIT) ? mem_rdata_i : hit_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_FLUSH;
      pend_q  <= 1'b0;
      fidx_q  <= '0;
      lfsr_q  <= LFSR_SEED;
      vaddr_q <= '0;
      byp_q   <= 1'b0;
      pline_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      if (st_q == S_FLUSH) fidx_q <= fidx_q + IDX_W'(1);
      if (accept) begin
        vaddr_q <= fetch_vaddr_i;
        byp_q   <= !cache_en_i;
        pline_q <= PLINE_W'(fetch_vaddr_i[VADDR_W-1:OFS_W]);
      end else if (st_q == S_LOOK && xlat_valid_i) begin
        pline_q <= xlat_pline_i;
      end
      if (install) lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & LFSR_TAPS)};
    end
  end

  always_ff @(posedge clk_i) begin
    if (st_q == S_FLUSH) vld_q[fidx_q] <= '0;
    if (install) begin
      vld_q[idx][victim]  <= 1'b1;
      tag_q[victim][idx]  <= pline_q[PLINE_W-1 -: TAG_W];
      data_q[victim][idx] <= mem_rdata_i;
    end
  end
endmodule

module icache_fetch_ctrl_chk #(
  parameter int VADDR_W = 32,
  parameter int PADDR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               kill_i,
  input logic               flush_i,
  input logic               fetch_ready_o,
  input logic               fetch_valid_o,
  input logic               xlat_req_o,
  input logic               xlat_valid_i,
  input logic [VADDR_W-1:0] xlat_vaddr_o,
  input logic               mem_req_o,
  input logic               mem_gnt_i,
  input logic [PADDR_W-1:0] mem_addr_o
);
  // R8
  xlat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_req_o && !xlat_valid_i |=> xlat_req_o && $stable(xlat_vaddr_o));

  // R5
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  // R10
  kill_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> !fetch_ready_o && !fetch_valid_o);

  // R11
  flush_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !fetch_ready_o);

  // R3
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xlat_req_o));
endmodule

bind icache_fetch_ctrl icache_fetch_ctrl_chk #(.VADDR_W(VADDR_W), .PADDR_W(PADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .kill_i(kill_i), .flush_i(flush_i),
  .fetch_ready_o(fetch_ready_o), .fetch_valid_o(fetch_valid_o),
  .xlat_req_o(xlat_req_o), .xlat_valid_i(xlat_valid_i), .xlat_vaddr_o(xlat_vaddr_o),
  .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_addr_o(mem_addr_o)
);

// File: tb/icache_fetch_ctrl_test.sv
module icache_fetch_ctrl_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_ni, cache_en_i, flush_i, kill_i, fetch_req_i;
  logic [31:0]  fetch_vaddr_i;
  logic         fetch_ready_o, fetch_valid_o;
  logic [127:0] fetch_data_o;
  logic         xlat_req_o, xlat_valid_i;
  logic [31:0]  xlat_vaddr_o;
  logic [27:0]  xlat_pline_i;
  logic         mem_req_o, mem_gnt_i, mem_rvalid_i;
  logic [31:0]  mem_addr_o;
  logic [127:0] mem_rdata_i;

  icache_fetch_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cache_en_i(cache_en_i), .flush_i(flush_i), .kill_i(kill_i),
    .fetch_req_i(fetch_req_i), .fetch_vaddr_i(fetch_vaddr_i), .fetch_ready_o(fetch_ready_o),
    .fetch_valid_o(fetch_valid_o), .fetch_data_o(fetch_data_o),
    .xlat_req_o(xlat_req_o), .xlat_vaddr_o(xlat_vaddr_o), .xlat_valid_i(xlat_valid_i),
    .xlat_pline_i(xlat_pline_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  localparam int PF = 0, PI = 1, PR = 2, PKX = 3, PM = 4, PKM = 5, PW = 6, PKW = 7;

  // stimulus
  logic f_req, k, fl, en;
  logic [31:0] f_addr;
  // agents
  int xlat_lat, gnt_lat, r_lat, xw, gw, rw;
  bit mbusy;
  logic [31:0] raddr;
  // model state
  int ph, fc, n_ph, n_fc;
  bit pend, n_pend, mbyp, n_byp, do_acc, do_inst, acc, last_ready;
  logic [31:0] mv, n_v;
  logic [27:0] pl, n_pl;
  logic [19:0] mtag [256][4];
  bit mval [256][4];
  logic [7:0] mlfsr;
  bit e_ready, e_valid, e_mreq, e_xreq;
  logic [127:0] e_data;
  logic [31:0] e_maddr;
  int nval, nmem, nx, misal;

  function automatic logic [127:0] linedata(logic [27:0] l);
    logic [31:0] x = {4'h0, l};
    return {x * 32'h9E37_79B9, x ^ 32'h5A5A_C3C3, ~x, x + 32'h1234_0001};
  endfunction

  function automatic logic [27:0] tr_line(logic [31:0] v);
    return {v[31:12] ^ 20'h80001, v[11:4]};
  endfunction

  task automatic chk(bit ok, string r, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    bit pd, hit;
    int ix;
    e_ready = 0; e_valid = 0; e_data = '0; e_mreq = 0; e_maddr = '0; e_xreq = 0;
    n_ph = ph; n_fc = fc; pd = pend | fl; n_pend = pd;
    do_acc = 0; do_inst = 0; n_pl = pl; n_v = mv; n_byp = mbyp;
    ix = int'(mv[11:4]);
    hit = 0;
    for (int w = 0; w < 4; w++)
      if (mval[ix][w] && mtag[ix][w] == xlat_pline_i[27:8]) hit = 1;
    case (ph)
      PF: begin n_fc = (fc + 1) % 256; if (fc == 255) n_ph = PI; end
      PI: if (pd) begin n_ph = PF; n_pend = 0; end
          else begin e_ready = !k; do_acc = e_ready && f_req; if (do_acc) n_ph = PR; end
      PR: begin
        e_xreq = !mbyp;
        if (mbyp) n_ph = k ? PI : PM;
        else if (xlat_valid_i) begin
          n_pl = xlat_pline_i;
          if (k) n_ph = PI;
          else if (hit) begin
            e_valid = 1; e_data = linedata(xlat_pline_i);
            e_ready = !pd; do_acc = e_ready && f_req;
            n_ph = do_acc ? PR : PI;
          end else n_ph = PM;
        end else if (k) n_ph = PKX;
      end
      PKX: begin e_xreq = 1; if (xlat_valid_i) n_ph = PI; end
      PM: begin
        e_mreq = 1; e_maddr = {pl, 4'h0};
        if (mem_gnt_i) n_ph = k ? PKW : PW; else if (k) n_ph = PKM;
      end
      PKM: begin e_mreq = 1; e_maddr = {pl, 4'h0}; if (mem_gnt_i) n_ph = PKW; end
      PW: if (mem_rvalid_i) begin
            if (!k) begin e_valid = 1; e_data = linedata(pl); do_inst = !mbyp; end
            n_ph = PI;
          end else if (k) n_ph = PKW;
      PKW: if (mem_rvalid_i) n_ph = PI;
      default: ;
    endcase
    if (do_acc) begin n_v = f_addr; n_byp = !en; n_pl = f_addr[31:4]; end
  endtask

  task automatic model_commit();
    int ix, vw;
    ix = int'(mv[11:4]);
    if (ph == PF) for (int w = 0; w < 4; w++) mval[fc][w] = 0;
    if (do_inst) begin
      vw = -1;
      for (int w = 0; w < 4; w++) if (!mval[ix][w] && vw < 0) vw = w;
      if (vw < 0) vw = int'(mlfsr[1:0]);
      mval[ix][vw] = 1;
      mtag[ix][vw] = pl[27:8];
      mlfsr = {mlfsr[6:0], mlfsr[7] ^ mlfsr[5] ^ mlfsr[4] ^ mlfsr[3]};
    end
    ph = n_ph; fc = n_fc; pend = n_pend; pl = n_pl; mv = n_v; mbyp = n_byp;
  endtask

  task automatic step();
    xlat_valid_i = xlat_req_o && (xw >= xlat_lat);
    xlat_pline_i = tr_line(xlat_vaddr_o);
    mem_gnt_i    = mem_req_o && (gw >= gnt_lat);
    mem_rvalid_i = mbusy && (rw >= r_lat);
    mem_rdata_i  = linedata(raddr[31:4]);
    fetch_req_i = f_req; fetch_vaddr_i = f_addr; kill_i = k; flush_i = fl; cache_en_i = en;
    #1;
    model_eval();
    chk(fetch_ready_o === e_ready, "R4 ready", 128'(fetch_ready_o), 128'(e_ready));
    chk(fetch_valid_o === e_valid, "R3 valid", 128'(fetch_valid_o), 128'(e_valid));
    if (e_valid) chk(fetch_data_o === e_data, "R5 data", fetch_data_o, e_data);
    chk(mem_req_o === e_mreq, "R5 mem_req", 128'(mem_req_o), 128'(e_mreq));
    if (e_mreq) chk(mem_addr_o === e_maddr, "R1 mem_addr", 128'(mem_addr_o), 128'(e_maddr));
    chk(xlat_req_o === e_xreq, "R3 xlat_req", 128'(xlat_req_o), 128'(e_xreq));
    if (e_xreq) chk(xlat_vaddr_o === mv, "R3 xlat_vaddr", 128'(xlat_vaddr_o), 128'(mv));
    acc = do_acc;
    last_ready = fetch_ready_o;
    if (fetch_valid_o) nval++;
    if (mem_req_o && mem_gnt_i) nmem++;
    if (mem_req_o && mem_addr_o[3:0] != 4'h0) misal++;
    if (xlat_req_o && xlat_valid_i) nx++;
    if (xlat_req_o && xlat_valid_i) xw = 0; else if (xlat_req_o) xw++;
    if (mem_rvalid_i) mbusy = 0; else if (mbusy) rw++;
    if (mem_req_o && mem_gnt_i) begin mbusy = 1; rw = 0; gw = 0; raddr = mem_addr_o; end
    else if (mem_req_o) gw++;
    model_commit();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr(); nval = 0; nmem = 0; nx = 0; endtask

  task automatic wait_idle();
    int g = 0;
    f_req = 0;
    while (ph != PI && g < 500) begin step(); g++; end
    step();
  endtask

  task automatic accept_one(logic [31:0] a, logic e);
    int g = 0;
    f_addr = a; en = e; f_req = 1;
    do begin step(); g++; end while (!acc && g < 500);
    f_req = 0;
  endtask

  task automatic fetch(logic [31:0] a, logic e);
    accept_one(a, e);
    wait_idle();
  endtask

  task automatic kill_at(logic [31:0] a, int target, int skip);
    int g = 0;
    accept_one(a, 1'b1);
    while (ph != target && g < 500) begin step(); g++; end
    repeat (skip) step();
    k = 1; step(); k = 0;
    wait_idle();
  endtask

  task automatic chk_eq(string r, int act, int exp);
    chk(act == exp, r, 128'(act), 128'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c, g;
    rst_ni = 0; f_req = 0; k = 0; fl = 0; en = 1; f_addr = '0;
    fetch_req_i = 0; fetch_vaddr_i = '0; kill_i = 0; flush_i = 0; cache_en_i = 1;
    xlat_valid_i = 0; xlat_pline_i = '0; mem_gnt_i = 0; mem_rvalid_i = 0; mem_rdata_i = '0;
    xlat_lat = 1; gnt_lat = 1; r_lat = 3; xw = 0; gw = 0; rw = 0; mbusy = 0; raddr = '0;
    ph = PF; fc = 0; pend = 0; mbyp = 0; mv = '0; pl = '0; mlfsr = 8'hA5;
    for (int s = 0; s < 256; s++) for (int w = 0; w < 4; w++) begin mval[s][w] = 0; mtag[s][w] = '0; end
    misal = 0; clr();
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R2: reset sweep keeps ready low for 256 cycles
    c = 0; g = 0;
    do begin step(); if (!last_ready) c++; g++; end while (!last_ready && g < 1000);
    chk_eq("R2 reset sweep cycles", c, 256);

    // R5: first fetch misses, refills and returns
    clr(); fetch(32'h0000_1040, 1);
    chk_eq("R5 miss reads memory once", nmem, 1);
    chk_eq("R5 miss returns line", nval, 1);
    // R3: refetch hits with one translation and no memory read
    clr(); fetch(32'h0000_1048, 1);
    chk_eq("R3 hit no memory read", nmem, 0);
    chk_eq("R3 hit returns line", nval, 1);

    // R4: chained hit acceptance with zero translation latency
    xlat_lat = 0; clr();
    accept_one(32'h0000_1040, 1);
    f_addr = 32'h0000_1044; f_req = 1; c = 0;
    do begin step(); c++; end while (!acc && c < 50);
    f_req = 0; wait_idle();
    chk_eq("R4 chained accept gap", c, 1);
    chk_eq("R4 chained two lines", nval, 2);

    // R10: kill in a hit cycle drops the data
    clr(); kill_at(32'h0000_1040, PR, 0);
    chk_eq("R10 kill in hit cycle", nval, 0);

    // R7: uncached fetches bypass translation and are not installed
    xlat_lat = 1; clr();
    fetch(32'h0000_2200, 0); fetch(32'h0000_2200, 0);
    chk_eq("R7 bypass memory reads", nmem, 2);
    chk_eq("R7 bypass no translation", nx, 0);
    chk_eq("R7 bypass data returned", nval, 2);

    // R8: kill while translation is outstanding
    xlat_lat = 3; clr();
    kill_at(32'h0000_3300, PR, 1);
    chk_eq("R8 kill xlat no data", nval, 0);
    chk_eq("R8 kill xlat handshake completes", nx, 1);

    // R9: kill during refill, then the line still misses
    xlat_lat = 1; r_lat = 4; clr();
    kill_at(32'h0000_4400, PW, 1);
    chk_eq("R9 kill refill no data", nval, 0);
    chk_eq("R9 kill refill read completes", nmem, 1);
    clr(); fetch(32'h0000_4400, 1);
    chk_eq("R9 killed line not installed", nmem, 1);

    // R6: fill one set, then evict exactly one way
    clr();
    for (int i = 0; i < 4; i++) fetch(32'h0010_0300 + i * 32'h1000, 1);
    for (int i = 0; i < 4; i++) fetch(32'h0010_0300 + i * 32'h1000, 1);
    chk_eq("R6 four ways fill without eviction", nmem, 4);
    clr(); fetch(32'h0010_4300, 1);
    for (int i = 0; i < 4; i++) fetch(32'h0010_0300 + i * 32'h1000, 1);
    chk_eq("R6 one victim evicted", nmem, 2);

    // R11: flush during refill is deferred, data still returned
    clr(); accept_one(32'h0000_5500, 1);
    g = 0; while (ph != PW && g < 100) begin step(); g++; end
    fl = 1; step(); fl = 0;
    g = 0; while (ph != PI && g < 100) begin step(); g++; end
    chk_eq("R11 deferred flush keeps data", nval, 1);
    c = 0; g = 0;
    do begin step(); if (!last_ready) c++; g++; end while (!last_ready && g < 1000);
    chk_eq("R11 flush sweep after refill", c, 257);

    // R2: flushed line misses again
    clr(); fetch(32'h0000_5500, 1);
    chk_eq("R2 line misses after flush", nmem, 1);

    // R1: no misaligned memory address seen
    chk_eq("R1 aligned reads", misal, 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule